// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit timer peripheral with a small register file. A prescaler divides the system clock by a programmable value from 1 to 256, with an optional further divide by 16. Each prescaler terminal count advances a 16-bit up-counter. When the counter sits at the programmed reference value on such a terminal count, a reference event flag is raised and the counter restarts from zero. An interrupt output follows that flag when the interrupt enable bit in the mode register is set.

Software drives the block through a simple synchronous write port and a combinational read port. Each access carries a byte offset and moves one whole register. Writing the mode or reference register restarts counting with the new settings. Writing the counter register loads the count directly. Event flags are cleared by writing ones to them. Clearing the enable bit while it is set acts as a soft reset: the reference register is cleared as well.

Top module: `ref_timer`

## Requirements
- R1: After reset, the mode, reference, capture, counter and event registers read zero and `irq_o` is low.
- R2: Reads decode these offsets: 0x00 mode, 0x04 reference, 0x08 capture, 0x0C counter, 0x11 event. The event value sits in bits [1:0] with upper bits zero. Every other offset reads zero.
- R3: The timer runs only when mode bit 0 is 1 and mode bits [2:1] equal 1 (system clock) or 2 (system clock divided by 16). In every other case the counter and prescaler hold at zero, and writes to the counter register leave it at zero.
- R4: The count advances once every D clock cycles. D is (mode[15:8] + 1) when the source is 1, and 16 × (mode[15:8] + 1) when the source is 2.
- R5: On the cycle where the counter equals a non-zero reference value and the prescaler completes a period, event bit 1 is set and the counter returns to zero. The first event therefore follows a restart by D × (reference + 1) cycles.
- R6: A reference value of zero means 65536 counts. The event sets, and the counter wraps to zero, on the tick that leaves count 0xFFFF.
- R7: A write to the mode or reference register clears the counter and the prescaler phase.
- R8: A write to the counter register loads the written value and restarts the prescaler phase. The next increment comes D cycles later.
- R9: A mode write that changes bit 0 from 1 to 0 clears the reference register and stores the written mode value. A mode write that keeps bit 0 at 1 leaves the reference register unchanged.
- R10: Event bit 0 is the capture flag and bit 1 is the reference flag. A write to the event register clears each bit written as 1 and leaves the others. A flag being set in the same cycle wins over its clear.
- R11: `irq_o` is high exactly when mode bit 4 and event bit 1 are both 1. This holds even while the timer is stopped.
- R12: The capture register holds the last value written to offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset of the accessed register |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Reference interrupt request |

## Verification
Assertions check the following on every cycle:
- the prescaler phase stays within its limit;
- a stopped counter sits at zero;
- every non-matching tick adds exactly one, and a match returns the counter to zero;
- the reference flag rises only after a prescaler tick;
- a soft reset clears the reference register;
- a write of one to the reference flag clears it.

The bench scenarios show the exact divisors and event times for both clock sources, the 65536-count wrap for a zero reference, and the prescaler restart on counter loads. They also show that unsupported sources stay stopped, that the interrupt depends on its mask, and the read map with its unmapped offsets.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE = 5'h00,
    OFS_REF  = 5'h04,
    OFS_CAP  = 5'h08,
    OFS_CNT  = 5'h0C,
    OFS_EVT  = 5'h11
  } reg_ofs_e;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SYS16 = 2'd2,
    SRC_RSV   = 2'd3
  } clk_src_e;

  function automatic logic src_supported(logic [1:0] src);
    return (src == SRC_SYS) || (src == SRC_SYS16);
  endfunction
endpackage

// File: rtl/ref_timer_prescale.sv
module ref_timer_prescale #(
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             div_en_i,
  output logic             tick_o
);
  localparam int unsigned PC_W = PRE_W + DIV_LOG2;

  logic [PC_W-1:0] pc_q, limit;
  logic at_end;

  // (pre+1)*2^DIV_LOG2 - 1 == {pre, all ones}
  generate
    if (DIV_LOG2 > 0) begin : g_div
      assign limit = div_en_i ? {pre_i, {DIV_LOG2{1'b1}}} : PC_W'(pre_i);
    end else begin : g_nodiv
      logic unused_div;
      assign unused_div = div_en_i;
      assign limit = pre_i;
    end
  endgenerate

  assign at_end = (pc_q == limit);
  assign tick_o = run_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            pc_q <= '0;
    else if (!run_i || restart_i || at_end) pc_q <= '0;
    else                                    pc_q <= pc_q + 1'b1;
  end

  assert_pc_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pc_q <= limit);
endmodule

// File: rtl/ref_timer_count.sv
module ref_timer_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic hit;

  // zero reference behaves as full 2^CNT_W period
  assign hit     = tick_i && ((ref_i == '0) ? (cnt_q == '1) : (cnt_q == ref_i));
  assign match_o = run_i && !restart_i && !load_i && hit;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (hit)                cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  assert_tick_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i && !load_i && tick_i && !match_o) |=>
      cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_match_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> cnt_q == '0);
endmodule

// File: rtl/ref_timer.sv
module ref_timer
  import ref_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned DIV_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int unsigned PRE_LSB = REG_W - PRE_W;

  logic [REG_W-1:0] mode_q, cap_q;
  logic [CNT_W-1:0] ref_q, cnt;
  logic [1:0]       evt_q, evt_clr;
  logic wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt;
  logic run, tick, match, soft_rst;

  assign wr_mode = wr_en_i && (addr_i == OFS_MODE);
  assign wr_ref  = wr_en_i && (addr_i == OFS_REF);
  assign wr_cap  = wr_en_i && (addr_i == OFS_CAP);
  assign wr_cnt  = wr_en_i && (addr_i == OFS_CNT);
  assign wr_evt  = wr_en_i && (addr_i == OFS_EVT);

  assign run      = mode_q[0] && src_supported(mode_q[2:1]);
  assign soft_rst = wr_mode && mode_q[0] && !wr_data_i[0];
  assign evt_clr  = wr_evt ? wr_data_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data_i;
      if (soft_rst)    ref_q <= '0;
      else if (wr_ref) ref_q <= CNT_W'(wr_data_i);
      if (wr_cap) cap_q <= wr_data_i;
      evt_q <= (evt_q & ~evt_clr) | {match, 1'b0};
    end
  end

  ref_timer_prescale #(.PRE_W(PRE_W), .DIV_LOG2(DIV_LOG2)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(wr_mode || wr_ref || wr_cnt),
    .pre_i    (mode_q[REG_W-1:PRE_LSB]),
    .div_en_i (mode_q[2:1] == SRC_SYS16),
    .tick_o   (tick)
  );

  ref_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (wr_mode || wr_ref),
    .load_i    (wr_cnt),
    .load_val_i(CNT_W'(wr_data_i)),
    .tick_i    (tick),
    .ref_i     (ref_q),
    .cnt_o     (cnt),
    .match_o   (match)
  );

  assign irq_o = mode_q[4] && evt_q[1];

  always_comb begin
    case (addr_i)
      OFS_MODE: rd_data_o = mode_q;
      OFS_REF:  rd_data_o = REG_W'(ref_q);
      OFS_CAP:  rd_data_o = cap_q;
      OFS_CNT:  rd_data_o = REG_W'(cnt);
      OFS_EVT:  rd_data_o = REG_W'(evt_q);
      default:  rd_data_o = '0;
    endcase
  end

  assert_flag_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[1]) |-> $past(tick));
  assert_soft_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> ref_q == '0);
  assert_evt_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && wr_data_i[1] && !match) |=> !evt_q[1]);
endmodule

// File: tb/sim_ref_timer.sv
`timescale 1ns/1ps
module sim_ref_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ref_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                         A_CNT = 5'h0C, A_EVT = 5'h11;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rchk(input string req, input logic [4:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    wr(A_MODE, 16'h0000);
    wr(A_REF, 16'h0000);
    wr(A_EVT, 16'h0003);
  endtask

  task automatic t_reset_map();
    rchk("R1 mode", A_MODE, 16'h0);
    rchk("R1 ref", A_REF, 16'h0);
    rchk("R1 cap", A_CAP, 16'h0);
    rchk("R1 cnt", A_CNT, 16'h0);
    rchk("R1 evt", A_EVT, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    wr(A_CAP, 16'hBEEF);
    rchk("R12 capture holds", A_CAP, 16'hBEEF);
    wr(A_MODE, 16'h0300);
    rchk("R2 mode readback", A_MODE, 16'h0300);
    wr(A_REF, 16'h1234);
    rchk("R2 ref readback", A_REF, 16'h1234);
    rchk("R2 unmapped 0x14", 5'h14, 16'h0);
    rchk("R2 unmapped 0x10", 5'h10, 16'h0);
    rchk("R2 capture unchanged", A_CAP, 16'hBEEF);
    cleanup();
  endtask

  task automatic t_prescale();
    wr(A_REF, 16'd4);
    wr(A_MODE, 16'h021B);          // pre=2 (D=3), src=1, irq en
    edges(14);
    rchk("R4 count after 14 cycles", A_CNT, 16'd4);
    rchk("R5 no flag yet", A_EVT, 16'h0);
    chk("R11 irq low", 16'(irq), 16'h0);
    edges(1);
    rchk("R5 wrap to zero", A_CNT, 16'd0);
    rchk("R5 flag at D*(ref+1)", A_EVT, 16'h2);
    chk("R11 irq high", 16'(irq), 16'h1);
    cleanup();
  endtask

  task automatic t_div16();
    wr(A_REF, 16'd2);
    wr(A_MODE, 16'h001D);          // pre=0, src=2 (D=16)
    edges(47);
    rchk("R4 div16 count", A_CNT, 16'd2);
    rchk("R5 div16 no flag", A_EVT, 16'h0);
    edges(1);
    rchk("R5 div16 flag", A_EVT, 16'h2);
    cleanup();
    wr(A_REF, 16'd1);
    wr(A_MODE, 16'h011D);          // pre=1, src=2 (D=32)
    edges(63);
    rchk("R4 div16 pre1 count", A_CNT, 16'd1);
    rchk("R4 div16 pre1 no flag", A_EVT, 16'h0);
    edges(1);
    rchk("R4 div16 pre1 flag", A_EVT, 16'h2);
    cleanup();
  endtask

  task automatic t_unsupported();
    wr(A_REF, 16'd1);
    wr(A_MODE, 16'h0009);          // src=0
    edges(20);
    rchk("R3 src0 stopped", A_CNT, 16'd0);
    rchk("R3 src0 no flag", A_EVT, 16'd0);
    wr(A_MODE, 16'h000F);          // src=3
    edges(20);
    rchk("R3 src3 stopped", A_CNT, 16'd0);
    wr(A_CNT, 16'h0055);
    edges(1);
    rchk("R3 load ignored when stopped", A_CNT, 16'd0);
    cleanup();
  endtask

  task automatic t_events_irq();
    wr(A_REF, 16'd1);
    wr(A_MODE, 16'h000B);          // D=1, irq disabled
    edges(2);
    rchk("R10 ref flag set", A_EVT, 16'h2);
    chk("R11 masked irq", 16'(irq), 16'h0);
    wr(A_MODE, 16'h0010);          // stop, enable irq
    chk("R11 irq while stopped", 16'(irq), 16'h1);
    rchk("R9 ref cleared by soft reset", A_REF, 16'h0);
    wr(A_EVT, 16'h0001);
    rchk("R10 writing bit0 keeps ref flag", A_EVT, 16'h2);
    chk("R11 irq kept", 16'(irq), 16'h1);
    wr(A_EVT, 16'h0002);
    rchk("R10 write-one clears", A_EVT, 16'h0);
    chk("R11 irq drops", 16'(irq), 16'h0);
    cleanup();
  endtask

  task automatic t_soft_reset();
    wr(A_REF, 16'd7);
    wr(A_MODE, 16'h000B);
    wr(A_MODE, 16'h020B);
    rchk("R9 enable kept, ref kept", A_REF, 16'd7);
    wr(A_MODE, 16'h0010);
    rchk("R9 ref wiped", A_REF, 16'd0);
    rchk("R9 new mode stored", A_MODE, 16'h0010);
    cleanup();
  endtask

  task automatic t_load_zero_ref();
    wr(A_MODE, 16'h000B);          // ref = 0, D=1
    wr(A_CNT, 16'hFFFE);
    rchk("R8 load", A_CNT, 16'hFFFE);
    edges(1);
    rchk("R6 count FFFF", A_CNT, 16'hFFFF);
    rchk("R6 no flag at FFFF", A_EVT, 16'h0);
    edges(1);
    rchk("R6 wrap to zero", A_CNT, 16'h0);
    rchk("R6 flag on wrap", A_EVT, 16'h2);
    wr(A_EVT, 16'h0003);
    wr(A_REF, 16'h0010);
    wr(A_MODE, 16'h020B);          // D=3
    edges(4);
    wr(A_CNT, 16'h000E);
    edges(2);
    rchk("R8 prescaler restarted", A_CNT, 16'h000E);
    edges(1);
    rchk("R8 first step after D", A_CNT, 16'h000F);
    edges(5);
    rchk("R5 at reference", A_CNT, 16'h0010);
    rchk("R5 no flag before tick", A_EVT, 16'h0);
    edges(1);
    rchk("R5 flag after load", A_EVT, 16'h2);
    cleanup();
  endtask

  task automatic t_restart();
    wr(A_REF, 16'd5);
    wr(A_MODE, 16'h000B);
    edges(3);
    rchk("R7 running", A_CNT, 16'd3);
    wr(A_REF, 16'd5);
    rchk("R7 ref write restarts", A_CNT, 16'd0);
    edges(5);
    rchk("R7 count after restart", A_CNT, 16'd5);
    rchk("R7 no early flag", A_EVT, 16'h0);
    edges(1);
    rchk("R7 flag timed from restart", A_EVT, 16'h2);
    wr(A_MODE, 16'h000B);
    rchk("R7 mode write restarts", A_CNT, 16'd0);
    cleanup();
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset_map();
    t_prescale();
    t_div16();
    t_unsupported();
    t_events_irq();
    t_soft_reset();
    t_load_zero_ref();
    t_restart();
    report();
  end
endmodule